// File: doc/BRIEF.md
# Programmable UART Transmit Framer

This block turns one parallel character into an asynchronous serial frame on a single output line. A character is handed over through a valid/ready handshake. The block then drives a start bit, 5 to 8 data bits, an optional parity bit and a selectable stop period. After that it drops its busy flag and can take the next character.

Bit timing comes from an internal rate generator. The generator divides the input clock by a 16-bit divisor and produces one oversampling tick per divisor period. Sixteen ticks make one bit time. The full divisor range from 1 to 65535 is available, which covers line rates from about 50 baud up to 460.8 kbaud on a suitable input clock. A divisor of 0 is treated as 65536. The format inputs and the divisor are captured when a character is accepted, so a frame that is in flight is never disturbed by a change on those inputs. A break input holds the line low without changing the frame timing.

Top module: `uart_tx_framer`

## Requirements
- R1: Out of reset and whenever no frame is in flight and break is low, `txd` is 1, `busy` is 0 and `in_ready` is 1.
- R2: A character is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. `in_ready` always equals the inverse of `busy`. `busy` is 1 from the cycle after acceptance onward. While `busy` is 1, `in_valid` and `in_data` have no effect.
- R3: A frame is sent in this order: one start bit at level 0, then the data bits starting with `in_data[0]`. The count of data bits is set by `word_len`: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R4: Each tick lasts D clocks, where D is `divisor`, or 65536 when `divisor` is 0. One bit time is 16 ticks, which is 16·D clocks.
- R5: With `par_en`=0 no parity bit is sent. With `par_en`=1 a parity bit follows the data, and its value is set as follows. If `par_stick`=1, the bit equals the inverse of `par_even`. Otherwise it equals the XOR of the data bits when `par_even`=1, and the inverse of that XOR when `par_even`=0.
- R6: With `stop_sel`=0 the stop period at level 1 lasts 16 ticks. With `stop_sel`=1 it lasts 24 ticks when `word_len`=00, and 32 ticks for any other word length.
- R7: `busy` stays 1 for exactly (16·(1 + data bits + parity bit) + stop ticks)·D clocks. The earliest next acceptance is on the edge one cycle after `busy` falls.
- R8: While `brk` is 1, `txd` is 0 whether or not a frame is in flight. The frame's timing and its remaining bits are not affected.
- R9: The divisor and all format inputs are sampled at acceptance. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| divisor | input | 16 | Clock divisor per oversampling tick (0 means 65536) |
| word_len | input | 2 | Data bit count code (5 + value) |
| stop_sel | input | 1 | 0: one stop bit; 1: two stop bits, or 1.5 at 5 data bits |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select (with stick: inverse of the forced level) |
| par_stick | input | 1 | Force the parity bit to a fixed level |
| brk | input | 1 | Hold the line at 0 |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character, LSB sent first |
| in_ready | output | 1 | Framer can accept a character |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame in flight |

## Verification
The hardest case to reach is a divisor of 0. A complete frame at that setting lasts millions of clocks, so the bench cannot wait for it to finish. Instead the bench accepts a character at that setting and checks, cycle by cycle, that the start bit is still being held about 20,000 clocks later. It then ends the frame with a reset. Two other cases need deliberate stimulus: holding `in_valid` through a whole frame while `in_data` changes, and changing the divisor and format in the middle of a frame. A queue-based model in the bench predicts the line level for every cycle of these cases.

// File: rtl/utx_pkg.sv
package utx_pkg;

  localparam int UTX_DATA_W = 8;

  typedef struct packed {
    logic [1:0] wlen;
    logic       stop2;
    logic       par_en;
    logic       par_even;
    logic       par_stick;
  } utx_fmt_t;

  function automatic int utx_nbits(logic [1:0] wlen);
    return 5 + int'(wlen);
  endfunction

  function automatic logic utx_parity(logic [UTX_DATA_W-1:0] d, logic [1:0] wlen,
                                      logic even, logic stick);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < UTX_DATA_W; i++)
      if (i < utx_nbits(wlen)) acc = acc ^ d[i];
    if (stick) return ~even;
    return even ? acc : ~acc;
  endfunction

  function automatic int utx_stop_ticks(logic stop2, logic [1:0] wlen, int osr);
    if (!stop2) return osr;
    if (wlen == 2'b00) return osr + osr / 2;
    return 2 * osr;
  endfunction

  function automatic int utx_frame_ticks(utx_fmt_t f, int osr);
    return (1 + utx_nbits(f.wlen) + int'(f.par_en)) * osr
           + utx_stop_ticks(f.stop2, f.wlen, osr);
  endfunction

endpackage

// File: rtl/utx_baud_gen.sv
module utx_baud_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  // A divisor of 0 wraps to all ones, so the period becomes 2**DIV_W clocks.
  assign lim  = div - 1'b1;
  assign tick = en && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!en || tick) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/utx_frame_seq.sv
module utx_frame_seq
  import utx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  logic [UTX_DATA_W-1:0] data,
  input  utx_fmt_t              fmt,
  input  logic                  tick,
  output logic                  busy,
  output logic                  line_bit,
  output logic                  frame_done
);
  localparam int DATA_W    = UTX_DATA_W;
  localparam int FRAME_W   = DATA_W + 2;
  localparam int MAX_TICKS = (DATA_W + 4) * OSR;
  localparam int TCNT_W    = $clog2(MAX_TICKS);

  logic [FRAME_W-1:0] frame_q;
  logic [TCNT_W-1:0]  tcnt;
  logic [TCNT_W-1:0]  last_q;
  logic               busy_q;
  logic [TCNT_W-1:0]  bidx;

  function automatic logic [FRAME_W-1:0] build_frame(logic [DATA_W-1:0] d, utx_fmt_t f);
    logic [FRAME_W-1:0] v;
    int n;
    n = utx_nbits(f.wlen);
    v = '1;
    v[0] = 1'b0;
    for (int k = 0; k < DATA_W; k++)
      if (k < n) v[k+1] = d[k];
    if (f.par_en) v[n+1] = utx_parity(d, f.wlen, f.par_even, f.par_stick);
    return v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      tcnt    <= '0;
      last_q  <= '0;
      frame_q <= '1;
    end else if (accept) begin
      busy_q  <= 1'b1;
      tcnt    <= '0;
      last_q  <= TCNT_W'(utx_frame_ticks(fmt, OSR) - 1);
      frame_q <= build_frame(data, fmt);
    end else if (busy_q && tick) begin
      if (tcnt == last_q) begin
        busy_q <= 1'b0;
        tcnt   <= '0;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign bidx = TCNT_W'(int'(tcnt) / OSR);

  always_comb begin
    line_bit = 1'b1;
    for (int j = 0; j < FRAME_W; j++)
      if (int'(bidx) == j) line_bit = frame_q[j];
  end

  assign busy       = busy_q;
  assign frame_done = busy_q && tick && (tcnt == last_q);
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import utx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OSR   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIV_W-1:0]      divisor,
  input  logic [1:0]            word_len,
  input  logic                  stop_sel,
  input  logic                  par_en,
  input  logic                  par_even,
  input  logic                  par_stick,
  input  logic                  brk,
  input  logic                  in_valid,
  input  logic [UTX_DATA_W-1:0] in_data,
  output logic                  in_ready,
  output logic                  txd,
  output logic                  busy
);
  logic             accept_w;
  logic             tick_w;
  logic             done_w;
  logic             line_w;
  logic             busy_w;
  logic [DIV_W-1:0] div_q;
  utx_fmt_t         fmt_w;

  assign fmt_w    = '{wlen: word_len, stop2: stop_sel, par_en: par_en,
                      par_even: par_even, par_stick: par_stick};
  assign in_ready = !busy_w;
  assign accept_w = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= '0;
    else if (accept_w) div_q <= divisor;
  end

  utx_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (busy_w),
    .div  (div_q),
    .tick (tick_w)
  );

  utx_frame_seq #(.OSR(OSR)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept_w),
    .data      (in_data),
    .fmt       (fmt_w),
    .tick      (tick_w),
    .busy      (busy_w),
    .line_bit  (line_w),
    .frame_done(done_w)
  );

  assign busy = busy_w;
  assign txd  = brk ? 1'b0 : (busy_w ? line_w : 1'b1);
endmodule

// File: rtl/utx_checker.sv
module utx_checker (
  input logic clk,
  input logic rst_n,
  input logic brk,
  input logic in_ready,
  input logic busy,
  input logic txd,
  input logic accept,
  input logic tick,
  input logic frame_done
);
  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk) |-> txd);

  p_ready_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready != busy);

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  p_start_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!txd || brk));

  p_tick_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> busy);

  p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_done) |=> busy);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !busy);

  p_break_space_r8: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);
endmodule

bind uart_tx_framer utx_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .brk       (brk),
  .in_ready  (in_ready),
  .busy      (busy),
  .txd       (txd),
  .accept    (accept_w),
  .tick      (tick_w),
  .frame_done(done_w)
);

// File: tb/uart_tx_framer_bench.sv
module uart_tx_framer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic [1:0]  word_len = 2'b11;
  logic        stop_sel = 1'b0, par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic        brk = 1'b0, in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready, txd, busy;

  int    nchk = 0, nfail = 0, cyc = 0;
  bit    cmp_en = 0, finished = 0;
  string cur_req = "R1";

  bit lvl_q[$];
  int cnt_q[$];
  int exp_len = 0, blen = 0;
  bit prev_busy = 0;

  always #10 clk = ~clk;

  uart_tx_framer u_uart_tx_framer (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .word_len(word_len),
    .stop_sel(stop_sel), .par_en(par_en), .par_even(par_even),
    .par_stick(par_stick), .brk(brk), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .txd(txd), .busy(busy));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic add_seg(input bit lvl, input int n);
    lvl_q.push_back(lvl);
    cnt_q.push_back(n);
    exp_len += n;
  endtask

  // Behavioural frame model: a list of (level, clock count) segments.
  task automatic push_frame();
    int d, nb, ones, st;
    bit p;
    d  = (divisor == 0) ? 65536 : int'(divisor);
    nb = 5 + int'(word_len);
    exp_len = 0;
    add_seg(1'b0, 16 * d);
    ones = 0;
    for (int i = 0; i < nb; i++) begin
      add_seg(in_data[i], 16 * d);
      ones += int'(in_data[i]);
    end
    if (par_en) begin
      if (par_stick) p = ~par_even;
      else           p = par_even ? bit'(ones % 2) : ~bit'(ones % 2);
      add_seg(p, 16 * d);
    end
    if (!stop_sel)            st = 16;
    else if (word_len == 2'b00) st = 24;
    else                      st = 32;
    add_seg(1'b1, st * d);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      lvl_q.delete();
      cnt_q.delete();
    end else if (lvl_q.size() != 0) begin
      cnt_q[0] = cnt_q[0] - 1;
      if (cnt_q[0] == 0) begin
        void'(lvl_q.pop_front());
        void'(cnt_q.pop_front());
      end
    end else if (in_valid) begin
      push_frame();
    end
  end

  always @(negedge clk) begin
    bit eb, et;
    if (cmp_en && rst_n) begin
      eb = (lvl_q.size() != 0);
      et = brk ? 1'b0 : (eb ? lvl_q[0] : 1'b1);
      check(txd === et && busy === eb && in_ready === !eb, cur_req,
            "txd/busy/ready", int'({txd, busy, in_ready}), int'({et, eb, !eb}));
      if (busy) blen++;
      else if (prev_busy) begin
        check(blen == exp_len, "R7", "busy length", blen, exp_len);
        blen = 0;
      end
      prev_busy = busy;
    end else begin
      blen = 0;
      prev_busy = 0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 190000 && !finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog %s actual=%0d expected=%0d", cur_req, cyc, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic setfmt(input logic [15:0] d, input logic [1:0] wl, input bit st,
                        input bit pe, input bit pev, input bit pst);
    divisor = d; word_len = wl; stop_sel = st;
    par_en = pe; par_even = pev; par_stick = pst;
  endtask

  task automatic send(input logic [7:0] data);
    while (!in_ready) @(negedge clk);
    in_data = data;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    check(txd === 1'b1, "R1", "idle txd", int'(txd), 1);
    check(busy === 1'b0, "R1", "idle busy", int'(busy), 0);
    check(in_ready === 1'b1, "R1", "idle ready", int'(in_ready), 1);
    cmp_en = 1;
    repeat (5) @(negedge clk);

    // R3: word lengths and bit order
    cur_req = "R3";
    setfmt(16'd1, 2'b11, 0, 0, 0, 0); send(8'hA5);
    setfmt(16'd1, 2'b00, 0, 0, 0, 0); send(8'h3C);
    setfmt(16'd1, 2'b01, 0, 0, 0, 0); send(8'hE7);
    setfmt(16'd1, 2'b10, 0, 0, 0, 0); send(8'h4B);

    // R5: parity modes
    cur_req = "R5";
    setfmt(16'd1, 2'b11, 0, 1, 1, 0); send(8'h5A);
    setfmt(16'd1, 2'b11, 0, 1, 0, 0); send(8'h5A);
    setfmt(16'd1, 2'b10, 0, 1, 1, 0); send(8'h01);
    setfmt(16'd1, 2'b01, 0, 1, 0, 0); send(8'hFE);
    setfmt(16'd1, 2'b11, 0, 1, 1, 1); send(8'h7F);
    setfmt(16'd1, 2'b11, 0, 1, 0, 1); send(8'h80);

    // R6: stop lengths
    cur_req = "R6";
    setfmt(16'd2, 2'b00, 1, 0, 0, 0); send(8'h15);
    setfmt(16'd2, 2'b11, 1, 1, 1, 0); send(8'hC3);
    setfmt(16'd2, 2'b01, 1, 0, 0, 0); send(8'h2A);

    // R4: other divisors
    cur_req = "R4";
    setfmt(16'd3, 2'b11, 0, 0, 0, 0); send(8'h96);
    setfmt(16'd100, 2'b00, 0, 0, 0, 0); send(8'h0D);

    // R2/R7: valid held across frames, data changes while busy
    cur_req = "R2";
    setfmt(16'd1, 2'b11, 0, 0, 0, 0);
    in_data = 8'h11; in_valid = 1'b1;
    @(negedge clk);
    in_data = 8'hEE;
    while (busy) @(negedge clk);
    check(in_ready === 1'b1, "R7", "ready after frame", int'(in_ready), 1);
    @(negedge clk);
    check(busy === 1'b1, "R2", "second accept", int'(busy), 1);
    in_valid = 1'b0;
    while (busy) @(negedge clk);

    // R9: change format and divisor mid-frame
    cur_req = "R9";
    setfmt(16'd2, 2'b11, 1, 1, 1, 0);
    in_data = 8'h69; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    setfmt(16'd5, 2'b00, 0, 0, 0, 1);
    in_data = 8'h00;
    while (busy) @(negedge clk);

    // R8: break during frame and while idle
    cur_req = "R8";
    setfmt(16'd1, 2'b11, 0, 1, 0, 0);
    in_data = 8'hFF; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (40) @(negedge clk);
    brk = 1'b1;
    repeat (50) @(negedge clk);
    check(txd === 1'b0, "R8", "break low", int'(txd), 0);
    brk = 1'b0;
    while (busy) @(negedge clk);
    brk = 1'b1;
    repeat (10) @(negedge clk);
    check(txd === 1'b0 && busy === 1'b0, "R8", "idle break", int'({txd, busy}), 0);
    brk = 1'b0;
    repeat (3) @(negedge clk);

    // R4: divisor 0 means 65536 clocks per tick
    cur_req = "R4";
    setfmt(16'd0, 2'b11, 0, 0, 0, 0);
    in_data = 8'hFF; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (20000) @(negedge clk);
    check(busy === 1'b1 && txd === 1'b0, "R4", "divisor 0 still in start bit",
          int'({busy, txd}), 2);
    cmp_en = 0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd === 1'b1 && busy === 1'b0, "R1", "after reset", int'({txd, busy}), 2);

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule